// File: doc/BRIEF.md
# Priority Round-Robin Request Arbiter

This block decides which of four requesters may use one shared output channel, for example the address channel of one target port in an on-chip switch. Each requester raises a valid-style request line. A parameter gives each requester a fixed priority level. The arbiter returns a one-hot grant vector. A transfer is complete when the shared channel's ready input is high while a grant is active.

Among the active requesters, those at the highest priority level compete. Inside that level, a circular pointer picks the first requester at or after the requester that follows the one most recently served. The arbiter locks the grant while a granted transfer waits for ready, so the winner cannot change under a stalled transfer. The grant is produced combinationally from the request lines and a small amount of state. A new winner can therefore be served in the cycle right after the previous handshake, with no idle cycle between them.

Payload steering is left to the surrounding logic, which uses the grant vector as its select.

Top module: `prio_rr_arbiter`

## Requirements
- R1: `grant_o` has at most one bit set, and a set bit is always on a requester whose `req_i` bit is high in that cycle.
- R2: When `req_i` is all zeros, `grant_o` is all zeros in the same cycle.
- R3: Requester i has priority `REQ_PRIO[i*PRIO_W +: PRIO_W]`, and a larger value wins. When no lock is held, the grant goes to a requester at the highest level present among the active requests.
- R4: Within the winning level, the grant goes to the first active requester met when scanning circularly upward from the pointer. After a completed transfer by requester k, the pointer holds (k+1) mod 4.
- R5: After reset, the pointer selects requester 0 first. With all requests active at equal level, requester 0 is granted first.
- R6: While the granted requester keeps its request high and `grant_ready_i` is low, the grant stays on that requester in the next cycle. This holds even when a higher-priority request appears.
- R7: The pointer changes only on a completed transfer (any grant bit high and `grant_ready_i` high). Idle cycles and stalled cycles leave it unchanged.
- R8: Whenever any request is active, some grant is active in the same cycle. After a completed transfer, a waiting requester is granted in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_REQ | Request line per requester |
| grant_ready_i | input | 1 | Shared channel accepts the granted transfer |
| grant_o | output | N_REQ | One-hot grant, zero when idle |

## Verification
Two functions can act in the same cycle. A completed transfer moves the pointer, and in that same cycle a fresh winner must be chosen from the requests that are still pending. Separately, a held lock can be released while a higher-priority request is already present. The bench provokes both by keeping every line requesting across consecutive ready cycles, and by raising a higher-priority request under a stalled grant and then releasing ready. A bench-side priority and pointer model judges each cycle's grant, together with an LFSR-driven sweep over all request and ready combinations.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;

  // Circular successor of an index in a ring of n entries.
  function automatic int unsigned ring_next(input int unsigned idx, input int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/prio_level_filter.sv
module prio_level_filter #(
  parameter int N_REQ  = 4,
  parameter int PRIO_W = 2,
  parameter logic [N_REQ*PRIO_W-1:0] REQ_PRIO = '0
) (
  input  logic [N_REQ-1:0]  req_i,
  output logic [N_REQ-1:0]  top_mask_o,
  output logic [PRIO_W-1:0] top_level_o
);
  localparam int NLVL = 1 << PRIO_W;

  logic [N_REQ-1:0] lvl_mask [NLVL];

  for (genvar gl = 0; gl < NLVL; gl++) begin : g_lvl
    for (genvar gi = 0; gi < N_REQ; gi++) begin : g_req
      assign lvl_mask[gl][gi] = req_i[gi] && (REQ_PRIO[gi*PRIO_W +: PRIO_W] == PRIO_W'(gl));
    end
  end

  // Ascending scan: the last non-empty level seen is the highest.
  always_comb begin
    top_mask_o  = '0;
    top_level_o = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (|lvl_mask[PRIO_W'(l)]) begin
        top_mask_o  = lvl_mask[PRIO_W'(l)];
        top_level_o = PRIO_W'(l);
      end
    end
  end

endmodule

// File: rtl/rr_select.sv
module rr_select #(
  parameter int N_REQ = 4,
  parameter int IDX_W = 2
) (
  input  logic [N_REQ-1:0] cand_i,
  input  logic [IDX_W-1:0] ptr_i,
  output logic [N_REQ-1:0] pick_vec_o,
  output logic [IDX_W-1:0] pick_idx_o
);
  logic             found;
  logic [IDX_W-1:0] pos;

  always_comb begin
    pick_vec_o = '0;
    pick_idx_o = '0;
    found      = 1'b0;
    pos        = '0;
    for (int k = 0; k < N_REQ; k++) begin
      pos = IDX_W'((int'(ptr_i) + k) % N_REQ);
      if (!found && cand_i[pos]) begin
        found           = 1'b1;
        pick_vec_o[pos] = 1'b1;
        pick_idx_o      = pos;
      end
    end
  end

endmodule

// File: rtl/prio_rr_arbiter.sv
module prio_rr_arbiter #(
  parameter int N_REQ  = 4,
  parameter int PRIO_W = 2,
  parameter logic [N_REQ*PRIO_W-1:0] REQ_PRIO = 8'h11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_REQ-1:0] req_i,
  input  logic             grant_ready_i,
  output logic [N_REQ-1:0] grant_o
);
  import prio_arb_pkg::*;

  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;

  logic [IDX_W-1:0]  ptr_q;
  logic              lock_q;
  logic [N_REQ-1:0]  lock_vec_q;
  logic [IDX_W-1:0]  lock_idx_q;

  logic [N_REQ-1:0]  top_mask;
  logic [PRIO_W-1:0] top_level;
  logic [N_REQ-1:0]  pick_vec;
  logic [IDX_W-1:0]  pick_idx;
  logic              hold;
  logic [IDX_W-1:0]  win_idx;
  logic              xfer;

  prio_level_filter #(
    .N_REQ(N_REQ), .PRIO_W(PRIO_W), .REQ_PRIO(REQ_PRIO)
  ) u_filter (
    .req_i(req_i), .top_mask_o(top_mask), .top_level_o(top_level)
  );

  rr_select #(
    .N_REQ(N_REQ), .IDX_W(IDX_W)
  ) u_rr (
    .cand_i(top_mask), .ptr_i(ptr_q), .pick_vec_o(pick_vec), .pick_idx_o(pick_idx)
  );

  // A lock survives only while its owner still requests.
  assign hold    = lock_q && |(lock_vec_q & req_i);
  assign grant_o = hold ? lock_vec_q : pick_vec;
  assign win_idx = hold ? lock_idx_q : pick_idx;
  assign xfer    = (|grant_o) && grant_ready_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q      <= '0;
      lock_q     <= 1'b0;
      lock_vec_q <= '0;
      lock_idx_q <= '0;
    end else begin
      lock_q     <= (|grant_o) && !grant_ready_i;
      lock_vec_q <= grant_o;
      lock_idx_q <= win_idx;
      if (xfer) ptr_q <= IDX_W'(ring_next(int'(win_idx), N_REQ));
    end
  end

  // Priority level of the current grant, for checking only.
  logic [PRIO_W-1:0] grant_level;
  always_comb begin
    grant_level = '0;
    for (int i = 0; i < N_REQ; i++)
      if (grant_o[IDX_W'(i)]) grant_level = REQ_PRIO[i*PRIO_W +: PRIO_W];
  end

  // R1
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o));

  // R1
  grant_subset_chk: assert property (@(posedge clk) disable iff (rst)
    (grant_o & ~req_i) == '0);

  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (req_i == '0) |-> (grant_o == '0));

  // R3
  top_level_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && (|grant_o)) |-> (grant_level == top_level));

  // R6
  hold_grant_chk: assert property (@(posedge clk) disable iff (rst)
    ((|grant_o) && !grant_ready_i) |=>
      ((grant_o == $past(grant_o)) || ((req_i & $past(grant_o)) == '0)));

  // R7
  ptr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !xfer |=> $stable(ptr_q));

  // R8
  no_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    (|req_i) |-> (|grant_o));

endmodule

// File: tb/prio_rr_arbiter_bench.sv
`timescale 1ns/1ps
module prio_rr_arbiter_bench;
  localparam logic [7:0] PRIOS = 8'h11; // r0=1 r1=0 r2=1 r3=0

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] req = '0;
  logic       rdy = 1'b0;
  logic [3:0] grant;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Bench model state
  int         m_ptr = 0;
  bit         m_lock = 0;
  logic [3:0] m_lock_vec = '0;

  always #2.5 clk = ~clk;

  prio_rr_arbiter #(.N_REQ(4), .PRIO_W(2), .REQ_PRIO(PRIOS)) u_prio_rr_arbiter (
    .clk(clk), .rst(rst), .req_i(req), .grant_ready_i(rdy), .grant_o(grant)
  );

  function automatic int prio_of(input int i);
    return int'(PRIOS[i*2 +: 2]);
  endfunction

  function automatic logic [3:0] model_grant(input logic [3:0] r);
    int best = -1;
    if (m_lock && ((r & m_lock_vec) != 0)) return m_lock_vec;
    for (int i = 0; i < 4; i++) if (r[i] && prio_of(i) > best) best = prio_of(i);
    if (best < 0) return 4'b0000;
    for (int k = 0; k < 4; k++) begin
      int p = (m_ptr + k) % 4;
      if (r[p] && prio_of(p) == best) return 4'b0001 << p;
    end
    return 4'b0000;
  endfunction

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: grant actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] r, input logic rd, input string tag);
    logic [3:0] e;
    @(negedge clk);
    req = r;
    rdy = rd;
    #1;
    e = model_grant(r);
    check(grant, e, tag);
    if (e != 0) begin
      int idx = 0;
      for (int i = 0; i < 4; i++) if (e[i]) idx = i;
      if (rd) m_ptr = (idx + 1) % 4;
    end
    m_lock     = (e != 0) && !rd;
    m_lock_vec = e;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R8: run actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    repeat (4) @(posedge clk);
    #1;
    check(grant, 4'b0000, "R2 during reset");
    @(negedge clk);
    rst = 1'b0;

    step(4'b0000, 1'b1, "R2 idle");
    step(4'b1111, 1'b0, "R5 first grant");
    check(grant, 4'b0001, "R5 literal");
    step(4'b1111, 1'b0, "R6 stall hold");
    step(4'b1111, 1'b1, "R6 accept");
    step(4'b1111, 1'b1, "R8 back-to-back");
    check(grant, 4'b0100, "R8 literal");
    step(4'b1111, 1'b1, "R4 wrap");
    step(4'b1010, 1'b0, "R3 low level only");
    step(4'b1011, 1'b0, "R6 higher prio under lock");
    check(grant, 4'b0010, "R6 literal");
    step(4'b1011, 1'b1, "R6 release");
    step(4'b0000, 1'b1, "R7 idle");
    step(4'b0000, 1'b0, "R7 idle stall");
    step(4'b1010, 1'b0, "R7 pointer kept");
    check(grant, 4'b1000, "R7 literal");
    step(4'b1010, 1'b1, "R7 accept");
    step(4'b0101, 1'b1, "R4 rotate a");
    step(4'b0101, 1'b1, "R4 rotate b");
    step(4'b0101, 1'b1, "R4 rotate c");
    step(4'b1111, 1'b1, "R3 mixed levels");

    // Exhaustive request/ready sweep, twice, in ascending order.
    for (int pass = 0; pass < 2; pass++)
      for (int v = 0; v < 32; v++) step(v[4:1], v[0], "R1 sweep");

    // Pseudo-random sweep
    lfsr = 8'hA5;
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[3:0], lfsr[6] | lfsr[5], "R4 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule